// File: doc/BRIEF.md
# Page-Buffered Serial Flash Write Sequencer

This block writes an arbitrary run of bytes into a serial flash whose array is divided into pages and which carries an on-chip SRAM page buffer. A request gives a linear byte address, a length and a verify flag. The write data follows as a byte stream with a valid/ready handshake. The block cuts the run into pieces that never straddle a page. A piece that covers only part of a page first has the old page copied into the buffer, so that the bytes the request does not touch survive. The block then issues one erase-and-program-through-buffer command per piece, and the piece's data bytes travel in the same chip-select window.

After every command that starts an internal flash operation, the block polls the status byte until the ready bit comes back. When verify is requested, the block compares the buffer with the freshly programmed page after each program step. A reported difference ends the request at once with an I/O error. The block contains its own SPI mode-0 shifter, and `bytes_done` reports how many bytes reached the flash, including when a request fails part way.

Top module: `flash_page_writer`

## Requirements
- R1: Out of reset and whenever no request is in progress, `spi_cs_n` is high, `spi_sck` is low, and `busy` and `in_ready` are low.
- R2: A request of length zero raises `done` one cycle after it is accepted, with both error flags low and `bytes_done` zero. No chip-select activity occurs.
- R3: A request whose address plus length exceeds PAGE_BYTES*NUM_PAGES raises `done` with `err_range` set. No chip-select activity occurs.
- R4: The first piece is the smaller of (PAGE_BYTES minus the starting offset) and the length. Every later piece starts at offset 0 and is a full page or the remainder. No piece crosses a page.
- R5: Before a piece shorter than a page, a four-byte frame is sent: opcode 0x53, then the 24-bit address (page index shifted left by PAGE_SHIFT, with the offset field zero), most significant byte first. A full-page piece gets no such frame.
- R6: Each piece is programmed with opcode 0x82, then the 24-bit address ((page << PAGE_SHIFT) + offset), most significant byte first, then the piece's data bytes, all inside one chip-select low window.
- R7: After every 0x53, 0x82 or 0x60 frame, the block sends status frames (opcode 0xD7, one dummy byte, status returned in the second byte) until status bit 7 reads 1. Only then does it start the next operation.
- R8: With verify set, each program poll is followed by a frame with opcode 0x60 and the page address (offset field zero), which is polled in turn.
- R9: If status bit 6 is 1 when a compare completes, the request ends with `err_io` set and no further frames. `bytes_done` then counts only the pieces before the failing one.
- R10: On success, `bytes_done` equals the request length when `done` rises.
- R11: `in_ready` is high only during the data phase of a program frame. Exactly the requested number of stream bytes is consumed.
- R12: The SPI link is mode 0. `spi_sck` idles low, `spi_mosi` changes only while `spi_sck` is low, and bytes go most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | AW | Starting linear byte address |
| req_len | input | LW | Byte count |
| req_verify | input | 1 | Compare buffer with flash after each program step |
| in_data | input | 8 | Write data byte |
| in_valid | input | 1 | Write data valid |
| in_ready | output | 1 | Write data accepted this cycle when high with `in_valid` |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse when a request finishes |
| err_range | output | 1 | Last request ran past the device end |
| err_io | output | 1 | Last request aborted on a compare mismatch |
| bytes_done | output | LW | Bytes committed by the last request |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
The assertions take for granted that the flash drives `spi_miso` only on falling `spi_sck` edges, so the value is settled when the block samples it on the rising one. They also assume `req_valid` is raised only while `busy` is low. The bench's flash model shifts its status byte out on falling clock edges. The bench issues requests only between `done` and the next start, so the assumptions hold. The data feeder keeps `in_valid` high past the end of each run and also stalls it on a fixed pattern, so that over-consumption and handshake gaps would both show up as wrong flash contents or wrong byte counts.

// File: rtl/flash_page_writer.sv
module flash_page_writer #(
  parameter int PAGE_BYTES = 264,
  parameter int PAGE_SHIFT = 9,
  parameter int NUM_PAGES  = 512,
  localparam int DEV_BYTES = PAGE_BYTES * NUM_PAGES,
  localparam int AW = $clog2(DEV_BYTES),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic          req_verify,
  input  logic [7:0]    in_data,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic          err_range,
  output logic          err_io,
  output logic [LW-1:0] bytes_done,
  output logic          spi_cs_n,
  output logic          spi_sck,
  output logic          spi_mosi,
  input  logic          spi_miso
);

  localparam int PW = $clog2(NUM_PAGES) + 1;
  localparam logic [LW-1:0] PAGE_L = LW'(PAGE_BYTES);
  localparam logic [LW:0]   DEV_L  = (LW+1)'(DEV_BYTES);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_FRAME, S_GAP, S_END} st_t;
  typedef enum logic [1:0] {K_LOAD, K_PROG, K_CMP, K_STAT} kind_t;

  st_t   st;
  kind_t kind, prev;

  logic [PW-1:0] pg;
  logic [LW-1:0] off, clen, rem, cnt, bi;
  logic          vfy, cs_q, sck_q;
  logic          sh_act, sh_half, rdy_bit, mis_bit;
  logic [2:0]    sh_cnt;
  logic [7:0]    sh_tx, tx_byte, op_code;
  logic          done_q, erange_q, eio_q;
  logic [23:0]   fa;

  wire [LW-1:0] room   = PAGE_L - off;
  wire [LW-1:0] clen_n = (rem < room) ? rem : room;
  wire [LW-1:0] nbytes = (kind == K_STAT) ? LW'(2) :
                         (kind == K_PROG) ? LW'(4) + clen : LW'(4);
  wire [23:0]   base_a = 24'(pg) << PAGE_SHIFT;
  wire [23:0]   prog_a = base_a + 24'(off);
  wire [LW:0]   end_a  = (LW+1)'(req_addr) + (LW+1)'(req_len);
  wire [PW-1:0] q_pg   = PW'(LW'(req_addr) / PAGE_L);
  wire [LW-1:0] r_off  = LW'(req_addr) % PAGE_L;

  wire in_phase  = (kind == K_PROG) && (bi >= LW'(4));
  wire more      = (st == S_FRAME) && (bi < nbytes);
  wire ld        = more && !sh_act && (!in_phase || in_valid);
  wire frame_end = (st == S_FRAME) && !sh_act && (bi >= nbytes);

  assign in_ready   = more && !sh_act && in_phase;
  assign busy       = (st != S_IDLE);
  assign done       = done_q;
  assign err_range  = erange_q;
  assign err_io     = eio_q;
  assign bytes_done = cnt;
  assign spi_cs_n   = cs_q;
  assign spi_sck    = sck_q;
  assign spi_mosi   = sh_tx[7];

  always_comb begin
    unique case (kind)
      K_LOAD:  op_code = 8'h53;
      K_PROG:  op_code = 8'h82;
      K_CMP:   op_code = 8'h60;
      default: op_code = 8'hD7;
    endcase
    fa = (kind == K_PROG) ? prog_a : base_a;
    if (bi == '0)              tx_byte = op_code;
    else if (kind == K_STAT)   tx_byte = 8'h00;
    else if (bi == LW'(1))     tx_byte = fa[23:16];
    else if (bi == LW'(2))     tx_byte = fa[15:8];
    else if (bi == LW'(3))     tx_byte = fa[7:0];
    else                       tx_byte = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  kind <= K_STAT;  prev <= K_STAT;
      pg <= '0;  off <= '0;  clen <= '0;  rem <= '0;  cnt <= '0;  bi <= '0;
      vfy <= 1'b0;  cs_q <= 1'b1;  sck_q <= 1'b0;
      sh_act <= 1'b0;  sh_half <= 1'b0;  sh_cnt <= '0;  sh_tx <= '0;
      rdy_bit <= 1'b0;  mis_bit <= 1'b0;
      done_q <= 1'b0;  erange_q <= 1'b0;  eio_q <= 1'b0;
    end else begin
      done_q <= 1'b0;

      if (ld) begin
        sh_act  <= 1'b1;
        sh_half <= 1'b0;
        sh_cnt  <= '0;
        sh_tx   <= tx_byte;
        bi      <= bi + LW'(1);
      end else if (sh_act) begin
        if (!sh_half) begin
          sh_half <= 1'b1;
          sck_q   <= 1'b1;
          if (sh_cnt == 3'd0) rdy_bit <= spi_miso;
          if (sh_cnt == 3'd1) mis_bit <= spi_miso;
        end else begin
          sh_half <= 1'b0;
          sck_q   <= 1'b0;
          sh_tx   <= {sh_tx[6:0], 1'b0};
          sh_cnt  <= sh_cnt + 3'd1;
          if (sh_cnt == 3'd7) sh_act <= 1'b0;
        end
      end

      unique case (st)
        S_IDLE: if (req_valid) begin
          erange_q <= 1'b0;
          eio_q    <= 1'b0;
          cnt      <= '0;
          if (req_len == '0) begin
            done_q <= 1'b1;
          end else if (end_a > DEV_L) begin
            erange_q <= 1'b1;
            done_q   <= 1'b1;
          end else begin
            pg  <= q_pg;
            off <= r_off;
            rem <= req_len;
            vfy <= req_verify;
            st  <= S_SETUP;
          end
        end
        S_SETUP: begin
          clen <= clen_n;
          kind <= (clen_n != PAGE_L) ? K_LOAD : K_PROG;
          bi   <= '0;
          cs_q <= 1'b0;
          st   <= S_FRAME;
        end
        S_FRAME: if (frame_end) begin
          cs_q <= 1'b1;
          st   <= S_GAP;
        end
        S_GAP: begin
          if (kind != K_STAT) begin
            prev <= kind;
            kind <= K_STAT;
            bi   <= '0;
            cs_q <= 1'b0;
            st   <= S_FRAME;
          end else if (!rdy_bit) begin
            bi   <= '0;
            cs_q <= 1'b0;
            st   <= S_FRAME;
          end else if (prev == K_LOAD) begin
            kind <= K_PROG;
            bi   <= '0;
            cs_q <= 1'b0;
            st   <= S_FRAME;
          end else if (prev == K_PROG && vfy) begin
            kind <= K_CMP;
            bi   <= '0;
            cs_q <= 1'b0;
            st   <= S_FRAME;
          end else if (prev == K_CMP && mis_bit) begin
            eio_q <= 1'b1;
            st    <= S_END;
          end else begin
            cnt <= cnt + clen;
            rem <= rem - clen;
            pg  <= pg + PW'(1);
            off <= '0;
            st  <= (rem == clen) ? S_END : S_SETUP;
          end
        end
        default: begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !in_ready && !spi_sck)); // R1
  AST_RANGE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err_range |-> spi_cs_n); // R3
  AST_CHUNK_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FRAME && kind == K_PROG) |-> ((LW+1)'(off) + (LW+1)'(clen) <= (LW+1)'(PAGE_BYTES))); // R4
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(err_range && err_io)); // R9
  AST_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bytes_done >= $past(bytes_done))); // R10
  AST_FEED_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!spi_cs_n && busy)); // R11
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R12
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi)); // R12

endmodule

// File: tb/sim_flash_page_writer.sv
module sim_flash_page_writer;
  localparam int PB = 12, PS = 4, NP = 8, DEV = PB * NP;
  localparam int AW = $clog2(DEV), LW = AW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_verify = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0]    in_data = 8'h00;
  logic          in_valid = 1'b0;
  wire           in_ready, busy, done, err_range, err_io;
  wire [LW-1:0]  bytes_done;
  wire           spi_cs_n, spi_sck, spi_mosi, spi_miso;

  flash_page_writer #(.PAGE_BYTES(PB), .PAGE_SHIFT(PS), .NUM_PAGES(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_verify(req_verify), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .busy(busy), .done(done),
    .err_range(err_range), .err_io(err_io), .bytes_done(bytes_done),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // flash model
  logic [7:0]  fl [DEV];
  logic [7:0]  refm [DEV];
  logic [7:0]  pbuf [PB];
  logic [7:0]  rb = 8'h00, op = 8'h00, out_sh = 8'h00;
  logic [23:0] fa = '0;
  bit          skip = 0, mism = 0;
  int fidx = 0, rbits = 0, busy_cnt = 0, pgi = 0;
  int n_cs = 0, n_load = 0, n_prog = 0, n_cmp = 0, n_stat = 0;
  int prog_a [32];
  int last_load_a = 0, last_cmp_a = 0, fault_at = 0, mosi_bad = 0;

  assign spi_miso = out_sh[7];

  always @(negedge spi_cs_n) begin
    fidx = 0; rbits = 0; fa = '0; n_cs++;
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    rb = {rb[6:0], spi_mosi};
    rbits++;
    if (rbits == 8) begin
      rbits = 0;
      if (fidx == 0) begin
        op = rb;
        if (rb == 8'hD7) begin
          out_sh = {(busy_cnt == 0), mism, 6'b0};
          skip = 1;
        end
      end else if (fidx <= 3) begin
        fa = {fa[15:0], rb};
      end else if (op == 8'h82) begin
        pbuf[int'(fa[PS-1:0]) + fidx - 4] = rb;
      end
      fidx++;
    end
  end

  always @(negedge spi_sck) begin
    if (skip) skip = 0;
    else out_sh = {out_sh[6:0], 1'b0};
  end

  always @(posedge spi_cs_n) if (fidx > 0) begin
    pgi = int'(fa >> PS);
    case (op)
      8'h53: begin
        for (int k = 0; k < PB; k++) pbuf[k] = fl[pgi*PB + k];
        n_load++; last_load_a = int'(fa); busy_cnt = 2;
      end
      8'h82: begin
        for (int k = 0; k < PB; k++) fl[pgi*PB + k] = pbuf[k];
        if (n_prog < 32) prog_a[n_prog] = int'(fa);
        n_prog++;
        if (n_prog == fault_at) fl[pgi*PB] = ~fl[pgi*PB];
        busy_cnt = 2;
      end
      8'h60: begin
        mism = 0;
        for (int k = 0; k < PB; k++) if (pbuf[k] != fl[pgi*PB + k]) mism = 1;
        n_cmp++; last_cmp_a = int'(fa); busy_cnt = 2;
      end
      8'hD7: begin
        n_stat++;
        if (busy_cnt > 0) busy_cnt--;
      end
      default: ;
    endcase
  end

  always @(spi_mosi) if (rst_n && spi_sck === 1'b1) mosi_bad++;

  // data feeder
  logic [7:0] src [40];
  int  feed_n = 0, idx = 0, cyc = 0;
  bit  feeding = 0, stall_en = 0, acc = 0;

  always @(negedge clk) begin
    cyc++;
    if (acc) idx++;
    in_valid = feeding && idx < feed_n && !(stall_en && cyc % 3 == 1);
    in_data  = in_valid ? src[idx] : 8'h00;
    acc      = in_valid && in_ready;
  end

  int t_run;

  task automatic run(input int addr, input int len, input bit vfy, input bit stall);
    for (int i = 0; i < 40; i++) src[i] = 8'(i * 29 + addr * 3 + len + 7);
    idx = 0;
    feed_n = (len + 4 > 40) ? 40 : len + 4;
    stall_en = stall;
    feeding = 1;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(addr); req_len = LW'(len); req_verify = vfy;
    t_run = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      t_run++;
    end while (!done && t_run < 20000);
    if (t_run >= 20000) check("watchdog", "request never finished", 0, 1);
    feeding = 0;
    @(negedge clk);
  endtask

  task automatic commit(input int addr, input int len);
    for (int i = 0; i < len; i++) refm[addr + i] = src[i];
  endtask

  task automatic image(input string r);
    int bad = 0;
    for (int i = 0; i < DEV; i++) if (fl[i] != refm[i]) bad++;
    check(r, "flash bytes differing from expected image", bad, 0);
  endtask

  task automatic t_reset;
    check("R1", "cs_n after reset", int'(spi_cs_n), 1);
    check("R1", "in_ready after reset", int'(in_ready), 0);
    check("R1", "busy after reset", int'(busy), 0);
    check("R12", "sck idle level", int'(spi_sck), 0);
  endtask

  task automatic t_zero;
    int c0 = n_cs;
    run(20, 0, 0, 0);
    check("R2", "cycles to done", t_run, 1);
    check("R2", "frames", n_cs - c0, 0);
    check("R2", "error flags", int'(err_range) + int'(err_io), 0);
    check("R2", "bytes_done", int'(bytes_done), 0);
  endtask

  task automatic t_range;
    int c0 = n_cs;
    run(90, 7, 0, 0);
    check("R3", "err_range", int'(err_range), 1);
    check("R3", "frames", n_cs - c0, 0);
    check("R3", "stream bytes taken", idx, 0);
    image("R3");
  endtask

  task automatic t_full;
    int l0 = n_load, p0 = n_prog;
    run(12, 12, 0, 0);
    commit(12, 12);
    check("R5", "load frames for full page", n_load - l0, 0);
    check("R6", "program frames", n_prog - p0, 1);
    check("R6", "program address", prog_a[p0], 1 << PS);
    check("R10", "bytes_done", int'(bytes_done), 12);
    image("R6");
  endtask

  task automatic t_span;
    int l0 = n_load, p0 = n_prog, s0 = n_stat;
    run(5, 20, 0, 1);
    commit(5, 20);
    check("R4", "program frames for 7+12+1", n_prog - p0, 3);
    check("R5", "load frames for two partial pieces", n_load - l0, 2);
    check("R5", "last load address", last_load_a, 2 << PS);
    check("R6", "first program address", prog_a[p0], 5);
    check("R4", "second program address", prog_a[p0 + 1], 1 << PS);
    check("R4", "third program address", prog_a[p0 + 2], 2 << PS);
    check("R7", "status polls (3 per operation)", n_stat - s0, 15);
    check("R11", "stream bytes taken", idx, 20);
    check("R10", "bytes_done", int'(bytes_done), 20);
    image("R4");
  endtask

  task automatic t_verify;
    int c0 = n_cmp, s0 = n_stat;
    run(40, 8, 1, 0);
    commit(40, 8);
    check("R8", "compare frames", n_cmp - c0, 1);
    check("R8", "compare address", last_cmp_a, 3 << PS);
    check("R7", "status polls", n_stat - s0, 9);
    check("R9", "err_io on clean compare", int'(err_io), 0);
    check("R10", "bytes_done", int'(bytes_done), 8);
    image("R8");
  endtask

  task automatic t_fault;
    int p0 = n_prog, c0 = n_cmp;
    fault_at = n_prog + 2;
    run(0, 30, 1, 0);
    fault_at = 0;
    check("R9", "err_io", int'(err_io), 1);
    check("R9", "bytes_done after abort", int'(bytes_done), 12);
    check("R9", "program frames before abort", n_prog - p0, 2);
    check("R9", "compare frames before abort", n_cmp - c0, 2);
    check("R11", "stream bytes taken", idx, 24);
    for (int i = 0; i < DEV; i++) refm[i] = fl[i];
  endtask

  task automatic t_edge;
    int p0 = n_prog, l0 = n_load;
    run(95, 1, 0, 1);
    commit(95, 1);
    check("R3", "err_range at last byte", int'(err_range), 0);
    check("R5", "load frames", n_load - l0, 1);
    check("R5", "load address", last_load_a, 7 << PS);
    check("R6", "program address", prog_a[p0], (7 << PS) + 11);
    check("R10", "bytes_done", int'(bytes_done), 1);
    image("R6");
  endtask

  initial begin
    for (int i = 0; i < DEV; i++) begin
      fl[i] = 8'(i * 7 + 3);
      refm[i] = fl[i];
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero();
    t_range();
    t_full();
    t_span();
    t_verify();
    t_fault();
    t_edge();
    check("R12", "mosi changes while sck high", mosi_bad, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule